// File: doc/BRIEF.md
# Mean of Four Stored Values

The block keeps a small bank of data registers and computes their arithmetic mean when asked. While it is idle, values are written one at a time through a write port: an enable, an address and data. A start request moves the controller into an accumulation phase. In that phase the registers are added into a widened accumulator, one per clock. A down-counter selects each register, starting from the highest index and ending at index zero.

Once every register has been added, one more cycle divides the total by the register count and stores the result in a registered mean output. The count is a power of two, so this division is a right shift. The block then raises done and keeps it high for as long as start stays high. When start drops, the block returns to idle and accepts new writes.

Top module: `mean_unit`

## Requirements
- R1: While reset is low (asynchronous, active-low), done reads 0 and the mean output reads 0.
- R2: While start stays low in idle, done stays 0 and the mean output keeps its value.
- R3: The mean output equals floor((r0+r1+r2+r3)/4), where rN is the value last written while idle to the address N. The address is 2 bits wide, with values 0 to 3.
- R4: Done first reads 1 after the sixth rising clock edge, counting from the edge that first samples start high. One edge enters accumulation, four edges add the registers from index 3 down to index 0, and one edge stores the quotient.
- R5: While done is 1 and start stays high, done stays 1 and the mean output does not change.
- R6: Done returns to 0 one rising edge after start is sampled low. A later start begins a fresh computation.
- R7: A write presented while the block is not idle has no effect on any register. The next computation still uses the earlier values.
- R8: All registers at full scale (255 for 8-bit data) give a mean of 255, so the accumulated sum does not overflow.
- R9: Register contents persist across computations until they are rewritten while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a computation; hold high until done is seen |
| wrEn | input | 1 | Write strobe for the register bank (honoured only when idle) |
| wrAddr | input | 2 | Register index to write |
| wrData | input | 8 | Value to write |
| meanOut | output | 8 | Registered mean of the bank |
| done | output | 1 | Result valid; held while start stays high |

## Verification
The bench builds the block with its default 8-bit data width and four registers. With these settings a full-scale bank exercises the widest accumulator value. Truncation of the remainder shows up when the sum is not a multiple of four. The two-bit address makes every register reachable with a short directed write. Random banks from a fixed seed are run alongside directed cases for zeros, full scale, writes during a busy phase and persistence across runs. Each run checks the exact latency to done, the hold of done and of the mean while start stays high, and the release of done after start drops.

// File: rtl/mean_pkg.sv
package mean_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCUM  = 2'd1,
    ST_DIVIDE = 2'd2,
    ST_FINISH = 2'd3
  } meanState_t;

  typedef struct packed {
    logic wrAllow;
    logic clrAcc;
    logic loadCnt;
    logic accEn;
    logic decCnt;
    logic divEn;
  } meanStrobes_t;

endpackage

// File: rtl/mean_ctrl.sv
module mean_ctrl
  import mean_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         cntZero,
  output meanStrobes_t strobes,
  output logic         done
);

  meanState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:   if (start)   nextState = ST_ACCUM;
      ST_ACCUM:  if (cntZero) nextState = ST_DIVIDE;
      ST_DIVIDE:              nextState = ST_FINISH;
      ST_FINISH: if (!start)  nextState = ST_IDLE;
      default:                nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes = '0;
    done    = 1'b0;
    case (state)
      ST_IDLE: begin
        strobes.wrAllow = 1'b1;
        strobes.clrAcc  = 1'b1;
        strobes.loadCnt = 1'b1;
      end
      ST_ACCUM: begin
        strobes.accEn  = 1'b1;
        strobes.decCnt = 1'b1;
      end
      ST_DIVIDE: strobes.divEn = 1'b1;
      ST_FINISH: done = 1'b1;
      default: ;
    endcase
  end

  // R4: the last addition hands over to the divide cycle
  a_r4_accum_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCUM && cntZero) |=> (state == ST_DIVIDE));

  // R5: done holds while start is held
  a_r5_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> done);

  // R6: done releases one edge after start drops
  a_r6_done_release: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done);

  // R7: at most one phase strobe active at a time
  a_r7_phase_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrAllow, strobes.accEn, strobes.divEn, done}));

endmodule

// File: rtl/mean_datapath.sv
module mean_datapath
  import mean_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int SUM_W   = DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  meanStrobes_t      strobes,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              cntZero,
  output logic [DATA_W-1:0] meanOut
);

  logic [DATA_W-1:0] regBank [NUM_REGS];
  logic [ADDR_W-1:0] idxCnt;
  logic [SUM_W-1:0]  accSum;
  logic [DATA_W-1:0] selVal;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_bank
      logic selWr;
      assign selWr = strobes.wrAllow && wrEn && (wrAddr == ADDR_W'(gi));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      regBank[gi] <= '0;
        else if (selWr) regBank[gi] <= wrData;
      end

      // R7: bank is frozen outside idle
      a_r7_bank_frozen: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.wrAllow |=> $stable(regBank[gi]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               idxCnt <= ADDR_W'(NUM_REGS - 1);
    else if (strobes.loadCnt) idxCnt <= ADDR_W'(NUM_REGS - 1);
    else if (strobes.decCnt)  idxCnt <= idxCnt - 1'b1;
  end

  assign cntZero = (idxCnt == '0);
  assign selVal  = regBank[idxCnt];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               accSum <= '0;
    else if (strobes.clrAcc) accSum <= '0;
    else if (strobes.accEn)  accSum <= accSum + {{ADDR_W{1'b0}}, selVal};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              meanOut <= '0;
    else if (strobes.divEn) meanOut <= accSum[SUM_W-1:ADDR_W];
  end

  // R8: accumulation never wraps
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accEn |=> (accSum >= $past(accSum)));

  // R5: mean changes only in the divide cycle
  a_r5_mean_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.divEn |=> $stable(meanOut));

endmodule

// File: rtl/mean_unit.sv
module mean_unit
  import mean_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] meanOut,
  output logic              done
);

  meanStrobes_t strobes;
  logic         cntZero;

  mean_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cntZero (cntZero),
    .strobes (strobes),
    .done    (done)
  );

  mean_datapath #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .cntZero (cntZero),
    .meanOut (meanOut)
  );

endmodule

// File: tb/mean_unit_tb_top.sv
module mean_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] meanOut;
  logic       done;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] model [4];

  always #2 clk = ~clk;

  mean_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .meanOut(meanOut), .done(done)
  );

  function automatic logic [7:0] expMean();
    logic [9:0] s;
    s = 10'(model[0]) + 10'(model[1]) + 10'(model[2]) + 10'(model[3]);
    return s[9:2];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    model[a] = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // start, optionally inject a write while busy, then check latency/hold/release
  task automatic runOp(input logic busyWr, input logic [7:0] expM);
    int cyc;
    logic [7:0] held;
    @(negedge clk);
    start = 1'b1;
    cyc = 0;
    while (cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (busyWr && cyc == 2) begin
        wrEn = 1'b1; wrAddr = 2'd0; wrData = ~model[0];
      end else begin
        wrEn = 1'b0;
      end
      if (done) break;
    end
    wrEn = 1'b0;
    check("R4 latency", cyc, 6);
    check("R3 mean", meanOut, expM);
    held = meanOut;
    repeat (3) @(negedge clk);
    check("R5 done hold", done, 1);
    check("R5 mean stable", meanOut, held);
    start = 1'b0;
    @(negedge clk);
    check("R6 done release", done, 0);
    check("R2 mean kept in idle", meanOut, held);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) model[i] = '0;
    #1;
    check("R1 done in reset", done, 0);
    check("R1 mean in reset", meanOut, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    repeat (5) @(negedge clk);
    check("R2 idle done low", done, 0);
    check("R2 idle mean", meanOut, 0);

    runOp(1'b0, 8'd0);

    for (int i = 0; i < 4; i++) writeReg(2'(i), 8'hFF);
    runOp(1'b0, 8'd255);                 // R8 full scale

    writeReg(2'd0, 8'd1); writeReg(2'd1, 8'd2);
    writeReg(2'd2, 8'd3); writeReg(2'd3, 8'd7);
    runOp(1'b0, 8'd3);                   // R3 truncation 13/4

    runOp(1'b1, expMean());              // R7 write while busy
    runOp(1'b0, expMean());              // R7 and R9: old values still used

    writeReg(2'd2, 8'd100);
    runOp(1'b0, expMean());              // R9 single rewrite

    for (int t = 0; t < 16; t++) begin
      for (int i = 0; i < 4; i++)
        if ($urandom_range(0, 3) != 0) writeReg(2'(i), 8'($urandom_range(0, 255)));
      runOp(($urandom_range(0, 1) == 1), expMean());
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule